// File: doc/BRIEF.md
# Two-Wire Slave Command Framer for a Dual Converter

This block is the serial front end of a two-channel converter control core. It watches a two-wire bus (clock and open-drain data) that is sampled from the system clock. It detects frame starts, repeated starts and stops, and checks the 7-bit slave address one bit at a time. Each byte it accepts is acknowledged by pulling data low, and the received bytes go to the command logic as a command byte and an optional data byte, each with a one-cycle strobe.

When the master addresses it for reading, the block returns two readback bytes supplied by the command logic, most significant bit first. It sends the second byte only if the master acknowledged the first. If an address bit mismatches, the block stops listening until the next start. After a stop it also ignores the clock. A stop that arrives in the same clock-high interval as the start that opened the frame is not honoured. A stop or start that cuts a received byte short raises an abort strobe, and no byte strobe follows.

The system clock must run at least eight times faster than the bus clock. Both bus lines pass through a synchronizer of parameterised depth. The upper six address bits are chosen by a variant parameter (0111_00 by default, 1011_00 for the alternate). The lowest address bit comes from a strap input.

Top module: `conv_i2c_slave`

## Requirements
- R1: With the default variant, the slave acknowledges an address byte whose upper seven bits equal {0111_00, addr_sel} by holding data low through the ninth clock. Read/write is the address byte's bit 0, where 0 means write and 1 means read.
- R2: On the first address bit that differs, the slave stops decoding. Until the next start it drives data for no later clock and raises no strobe.
- R3: The all-zero address byte 0x00 is never acknowledged.
- R4: In a write frame, the first byte after the address is acknowledged and presented on cmd_byte, received MSB first. cmd_valid pulses once, after the falling clock that ends that byte's acknowledge.
- R5: The next byte is acknowledged and presented on data_byte with a data_valid pulse. Its two lowest (sub-)bits are passed on exactly as received.
- R6: A repeated start without a stop restarts address decoding. The first byte after the new address is again treated as a command byte.
- R7: A stop or start that arrives after the second clock of a received byte, or during its acknowledge, produces one frame_abort pulse and no byte strobe for that byte. After a stop, clocked bytes are not acknowledged until a new start.
- R8: A stop in the same clock-high interval as the opening start is ignored, and the frame's address is decoded normally.
- R9: After a read-address acknowledge, the slave sends rd_hi MSB first. If the master acknowledges, it then sends rd_lo. sda_oe changes only while the bus clock is low.
- R10: If the master does not acknowledge the first readback byte, the slave releases data for the rest of the frame.
- R11: During and after reset, sda_oe and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 1 | Strap that sets the lowest address bit |
| rd_hi | input | 8 | First readback byte, captured at the read-address acknowledge |
| rd_lo | input | 8 | Second readback byte, captured with rd_hi |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| cmd_byte | output | 8 | Last received command byte |
| cmd_valid | output | 1 | One-cycle strobe for a new command byte |
| data_byte | output | 8 | Last received data byte |
| data_valid | output | 1 | One-cycle strobe for a new data byte |
| frame_abort | output | 1 | One-cycle strobe when a received byte is cut short |

## Verification
The bench aims at the places where bus conditions and bit counting meet. An address that differs only in its strap bit must not be acknowledged; a decoder that compared only the upper bits would acknowledge it. A stop placed inside the opening clock-high phase must not kill the frame; a design without that rule would stay silent for the address. A repeated start must reset the command/data alternation; a design that kept it would report the command as data. A stop four bits into a data byte must raise an abort and leave the data strobe silent, and a byte clocked after that stop must go unacknowledged. On the read side, the bench checks the second byte after a master acknowledge, checks that data is released after a master not-acknowledge, and flags any change of sda_oe while the clock is high.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 7;
    localparam int CNT_W     = $clog2(BYTE_BITS);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACKW,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TXEND,
        ST_MACK,
        ST_LOAD2
    } tw_state_e;

    typedef enum logic {
        ACK_ADDR,
        ACK_RX
    } tw_ack_e;

    typedef struct packed {
        logic scl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } tw_bus_ev_t;

    function automatic logic [ADDR_BITS-2:0] addr_upper(input int variant);
        return (variant == 1) ? 6'b101100 : 6'b011100;
    endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CW = STAGES * WIDTH;

    logic [CW-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[CW-WIDTH-1:0], d};
    end

    assign q = chain[CW-1 -: WIDTH];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect import tw_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_s,
    input  logic       sda_s,
    output tw_bus_ev_t ev
);
    logic scl_q;
    logic sda_q;
    logic low_seen;
    logic start_c;
    logic stop_raw;

    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_raw = scl_s & scl_q & ~sda_q & sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            low_seen <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            if (start_c)     low_seen <= 1'b0;
            else if (!scl_s) low_seen <= 1'b1;
        end
    end

    always_comb begin
        ev          = '0;
        ev.scl      = scl_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = start_c;
        ev.stop     = stop_raw & low_seen;
    end

    AST_NO_STOP_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $past(ev.start) |-> !ev.stop); // R8

endmodule

// File: rtl/tw_engine.sv
module tw_engine import tw_pkg::*; #(
    parameter int ADDR_VARIANT = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tw_bus_ev_t           ev,
    input  logic                 sda_s,
    input  logic                 addr_sel,
    input  logic [BYTE_BITS-1:0] rd_hi,
    input  logic [BYTE_BITS-1:0] rd_lo,
    output logic                 sda_oe,
    output logic [BYTE_BITS-1:0] cmd_byte,
    output logic                 cmd_valid,
    output logic [BYTE_BITS-1:0] data_byte,
    output logic                 data_valid,
    output logic                 frame_abort
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_TOP  = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] MID_CLOCK = CNT_W'(2);

    tw_state_e             state;
    tw_ack_e               ack_kind;
    logic [CNT_W-1:0]      cnt;
    logic [BYTE_BITS-1:0]  shreg;
    logic [BYTE_BITS-1:0]  lo_hold;
    logic                  rw;
    logic                  is_data;
    logic                  tx_second;
    logic [ADDR_BITS-1:0]  exp_addr;
    logic                  rx_pending;

    assign exp_addr = {addr_upper(ADDR_VARIANT), addr_sel};

    // a byte counts as cut short once its second clock has begun
    assign rx_pending = ((state == ST_RX) && (cnt >= MID_CLOCK)) ||
                        (((state == ST_ACKW) || (state == ST_ACK)) && (ack_kind == ACK_RX));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ack_kind    <= ACK_ADDR;
            cnt         <= '0;
            shreg       <= '0;
            lo_hold     <= '0;
            rw          <= 1'b0;
            is_data     <= 1'b0;
            tx_second   <= 1'b0;
            sda_oe      <= 1'b0;
            cmd_byte    <= '0;
            cmd_valid   <= 1'b0;
            data_byte   <= '0;
            data_valid  <= 1'b0;
            frame_abort <= 1'b0;
        end else begin
            cmd_valid   <= 1'b0;
            data_valid  <= 1'b0;
            frame_abort <= 1'b0;
            if (ev.start || ev.stop) begin
                frame_abort <= rx_pending;
                sda_oe      <= 1'b0;
                cnt         <= '0;
                is_data     <= 1'b0;
                state       <= ev.start ? ST_ADDR : ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                    end
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            if (cnt == LAST_BIT) begin
                                rw       <= sda_s;
                                ack_kind <= ACK_ADDR;
                                state    <= ST_ACKW;
                            end else if (sda_s != exp_addr[ADDR_TOP - cnt]) begin
                                state <= ST_IDLE;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_ACKW: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if ((ack_kind == ACK_ADDR) && rw) begin
                                shreg     <= rd_hi;
                                lo_hold   <= rd_lo;
                                tx_second <= 1'b0;
                                sda_oe    <= ~rd_hi[BYTE_BITS-1];
                                state     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                                if (ack_kind == ACK_RX) begin
                                    if (is_data) begin
                                        data_byte  <= shreg;
                                        data_valid <= 1'b1;
                                    end else begin
                                        cmd_byte  <= shreg;
                                        cmd_valid <= 1'b1;
                                    end
                                    is_data <= ~is_data;
                                end
                            end
                        end
                    end
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[BYTE_BITS-2:0], sda_s};
                            if (cnt == LAST_BIT) begin
                                ack_kind <= ACK_RX;
                                state    <= ST_ACKW;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            if (cnt == LAST_BIT) state <= ST_TXEND;
                            else                 cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            shreg  <= shreg << 1;
                            sda_oe <= ~shreg[BYTE_BITS-2];
                        end
                    end
                    ST_TXEND: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            if (!sda_s && !tx_second) state <= ST_LOAD2;
                            else                      state <= ST_IDLE;
                        end
                    end
                    ST_LOAD2: begin
                        if (ev.scl_fall) begin
                            shreg     <= lo_hold;
                            sda_oe    <= ~lo_hold[BYTE_BITS-1];
                            tx_second <= 1'b1;
                            cnt       <= '0;
                            state     <= ST_TX;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_OE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R9

    AST_STROBE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || data_valid) |-> $past(sda_oe)); // R4

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, data_valid, frame_abort})); // R7

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        frame_abort |-> $past(ev.start || ev.stop)); // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && $past(state == ST_IDLE)) |-> !sda_oe); // R2

endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave import tw_pkg::*; #(
    parameter int ADDR_VARIANT = 0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 addr_sel,
    input  logic [BYTE_BITS-1:0] rd_hi,
    input  logic [BYTE_BITS-1:0] rd_lo,
    output logic                 sda_oe,
    output logic [BYTE_BITS-1:0] cmd_byte,
    output logic                 cmd_valid,
    output logic [BYTE_BITS-1:0] data_byte,
    output logic                 data_valid,
    output logic                 frame_abort
);
    logic       scl_s;
    logic       sda_s;
    tw_bus_ev_t ev;

    tw_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   ({scl_s, sda_s})
    );

    tw_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (ev)
    );

    tw_engine #(
        .ADDR_VARIANT (ADDR_VARIANT)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .sda_s       (sda_s),
        .addr_sel    (addr_sel),
        .rd_hi       (rd_hi),
        .rd_lo       (rd_lo),
        .sda_oe      (sda_oe),
        .cmd_byte    (cmd_byte),
        .cmd_valid   (cmd_valid),
        .data_byte   (data_byte),
        .data_valid  (data_valid),
        .frame_abort (frame_abort)
    );

endmodule

// File: tb/conv_i2c_slave_tb.sv
module conv_i2c_slave_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b1;
    logic [7:0] rd_hi = 8'h5A;
    logic [7:0] rd_lo = 8'hC3;
    logic       sda_oe;
    logic [7:0] cmd_byte;
    logic       cmd_valid;
    logic [7:0] data_byte;
    logic       data_valid;
    logic       frame_abort;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int n_cmd = 0;
    int n_data = 0;
    int n_abort = 0;
    int viol = 0;
    logic [7:0] last_cmd = 8'h00;
    logic [7:0] last_data = 8'h00;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    conv_i2c_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .addr_sel    (addr_sel),
        .rd_hi       (rd_hi),
        .rd_lo       (rd_lo),
        .sda_oe      (sda_oe),
        .cmd_byte    (cmd_byte),
        .cmd_valid   (cmd_valid),
        .data_byte   (data_byte),
        .data_valid  (data_valid),
        .frame_abort (frame_abort)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (cmd_valid)   begin n_cmd++;  last_cmd = cmd_byte;   end
            if (data_valid)  begin n_data++; last_data = data_byte; end
            if (frame_abort) n_abort++;
            if (scl_m && scl_prev && (sda_oe != oe_prev)) viol++;
        end
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    typedef struct packed {
        logic       asel;
        logic [7:0] addr;
        logic [7:0] cmd;
        logic [7:0] dat;
        logic       ack;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 8'h72, 8'h31, 8'hA4, 1'b1},
        '{1'b1, 8'h70, 8'h12, 8'h34, 1'b0},
        '{1'b1, 8'h00, 8'h12, 8'h34, 1'b0},
        '{1'b0, 8'h70, 8'h6B, 8'h94, 1'b1},
        '{1'b1, 8'hB2, 8'h12, 8'h34, 1'b0},
        '{1'b1, 8'h72, 8'hF0, 8'h0F, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wr_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
        rd_bit(b);
        acked = ~b;
    endtask

    task automatic rd_byte(input logic master_ack, output logic [7:0] v);
        logic b;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            rd_bit(b);
            v = {v[6:0], b};
        end
        wr_bit(~master_ack);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic       a;
        logic [7:0] v;
        int         nc, nd, na;

        tick(8);
        chk("R11 sda_oe in reset", {15'd0, sda_oe}, 16'd0);
        rst = 1'b0;
        tick(8);
        chk("R11 sda_oe after reset", {15'd0, sda_oe}, 16'd0);
        chk("R11 strobes after reset", {13'd0, cmd_valid, data_valid, frame_abort}, 16'd0);

        // R1 R2 R3 R4 R5: table of write frames
        for (int i = 0; i < 6; i++) begin
            nc = n_cmd; nd = n_data;
            addr_sel = VECS[i].asel;
            bus_start();
            wr_byte(VECS[i].addr, a);
            chk(VECS[i].addr == 8'h00 ? "R3 general call ack" :
                (VECS[i].ack ? "R1 address ack" : "R2 mismatch ack"),
                {15'd0, a}, {15'd0, VECS[i].ack});
            wr_byte(VECS[i].cmd, a);
            chk("R4 command ack", {15'd0, a}, {15'd0, VECS[i].ack});
            wr_byte(VECS[i].dat, a);
            chk("R5 data ack", {15'd0, a}, {15'd0, VECS[i].ack});
            bus_stop();
            tick(4);
            if (VECS[i].ack) begin
                chk("R4 command strobes", 16'(n_cmd - nc), 16'd1);
                chk("R4 command value", {8'd0, last_cmd}, {8'd0, VECS[i].cmd});
                chk("R5 data strobes", 16'(n_data - nd), 16'd1);
                chk("R5 data value", {8'd0, last_data}, {8'd0, VECS[i].dat});
            end else begin
                chk("R2 no strobes when passive", 16'((n_cmd - nc) + (n_data - nd)), 16'd0);
            end
        end
        addr_sel = 1'b1;

        // R6: repeated start resets command/data alternation
        nc = n_cmd; nd = n_data; na = n_abort;
        bus_start();
        wr_byte(8'h72, a);
        wr_byte(8'h11, a);
        bus_rstart();
        wr_byte(8'h72, a);
        chk("R6 address ack after repeated start", {15'd0, a}, 16'd1);
        wr_byte(8'h22, a);
        wr_byte(8'h33, a);
        bus_stop();
        tick(4);
        chk("R6 two commands", 16'(n_cmd - nc), 16'd2);
        chk("R6 command after repeated start", {8'd0, last_cmd}, 16'h0022);
        chk("R6 one data byte", 16'(n_data - nd), 16'd1);
        chk("R6 data value", {8'd0, last_data}, 16'h0033);
        chk("R6 no abort on repeated start", 16'(n_abort - na), 16'd0);

        // R7: stop four bits into the data byte
        nc = n_cmd; nd = n_data; na = n_abort;
        bus_start();
        wr_byte(8'h72, a);
        wr_byte(8'h44, a);
        for (int i = 0; i < 4; i++) wr_bit(1'b1);
        bus_stop();
        tick(4);
        chk("R7 abort pulse", 16'(n_abort - na), 16'd1);
        chk("R7 no data strobe", 16'(n_data - nd), 16'd0);
        chk("R7 command kept", 16'(n_cmd - nc), 16'd1);
        scl_m = 1'b0; tick(Q);
        wr_byte(8'h72, a);
        chk("R7 no ack after stop", {15'd0, a}, 16'd0);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);

        // R8: stop inside the opening clock-high interval is ignored
        sda_m = 1'b1; scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
        wr_byte(8'h72, a);
        chk("R8 address ack after early stop", {15'd0, a}, 16'd1);
        bus_stop();

        // R9: read both readback bytes
        bus_start();
        wr_byte(8'h72, a);
        wr_byte(8'h77, a);
        bus_rstart();
        wr_byte(8'h73, a);
        chk("R9 read address ack", {15'd0, a}, 16'd1);
        rd_byte(1'b1, v);
        chk("R9 first readback byte", {8'd0, v}, 16'h005A);
        rd_byte(1'b0, v);
        chk("R9 second readback byte", {8'd0, v}, 16'h00C3);
        bus_stop();

        // R10: master not-acknowledge releases data
        bus_start();
        wr_byte(8'h73, a);
        chk("R10 read address ack", {15'd0, a}, 16'd1);
        rd_byte(1'b0, v);
        chk("R10 first byte", {8'd0, v}, 16'h005A);
        rd_byte(1'b1, v);
        chk("R10 released after nack", {8'd0, v}, 16'h00FF);
        bus_stop();
        tick(8);

        chk("R9 sda_oe stable while clock high", 16'(viol), 16'd0);
        chk("R7 total aborts", 16'(n_abort), 16'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule